// File: doc/BRIEF.md
# Overcurrent Delay Shutdown Timer

This block handles overcurrent events for one switching converter. The converter's low-side switch on-time is watched: a fixed number of system clocks after the low-side switch turns on, the digital overcurrent flag from the current-sense comparator is captured. The first captured overcurrent does not stop the converter at once. Instead it opens a grace window that lasts a fixed number of switching cycles, counted on the cycle-start strobe. During the window the converter runs in current-limit mode: whenever the overcurrent flag is high, the on-pulse of the current cycle is ended early.

When the window closes, the block looks only at the most recent captured sample. If overcurrent is still present, a shutdown request is latched and held until the block is disabled or reset. If it is clear, normal operation returns, the window counter clears, and any later overcurrent opens a new full-length window. The analog sensing and the threshold comparison sit outside the block and arrive as one digital flag.

Top module: `oc_delay_shutdown`

## Requirements
- R1: After reset, and one clock after `en_i` is seen low, `cyc_term_o`, `limit_o` and `shutdown_o` are all 0, and the shutdown latch is cleared.
- R2: The overcurrent flag is captured exactly SAMPLE_DLY clocks after a rising edge of `ls_on_i`, and only when `ls_on_i` has stayed high at every clock edge up to and including that one. A low-side pulse that lasts SAMPLE_DLY clocks or fewer captures nothing.
- R3: In normal operation, a captured overcurrent sets `limit_o` to 1 on the next clock.
- R4: The window ends on the WIN_CYC-th `cyc_tick_i` pulse after the window opened (default 8). Until then `shutdown_o` stays 0.
- R5: While the window is open, `cyc_term_o` is 1 one clock after `oc_i` is seen high and 0 one clock after it is seen low. In normal operation `cyc_term_o` is 0 whatever `oc_i` does.
- R6: If the latest captured sample is overcurrent when the window ends, `shutdown_o` becomes 1 and `limit_o` becomes 0 on that same clock.
- R7: If the latest captured sample is clear when the window ends, the block returns to normal (`limit_o` 0, `shutdown_o` 0). Overcurrent samples earlier in the window do not affect this decision.
- R8: Once set, `shutdown_o` stays 1 while `en_i` stays high, whatever `oc_i` does, and `cyc_term_o` is held at 1.
- R9: A captured overcurrent after a window that ended without a fault opens a fresh window of full length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Converter enable; low clears all state |
| cyc_tick_i | input | 1 | One-clock pulse at the start of each switching cycle |
| ls_on_i | input | 1 | Low-side switch on (level) |
| oc_i | input | 1 | Overcurrent flag from the current comparator |
| cyc_term_o | output | 1 | End the present on-pulse early (current limit) |
| limit_o | output | 1 | Grace window open |
| shutdown_o | output | 1 | Latched shutdown request |

## Verification
A capture lands SAMPLE_DLY clocks after the low-side rising edge, and `limit_o` follows one clock after that. `shutdown_o` or the return to normal shows up right after the clock that sees the window's last cycle tick, and `cyc_term_o` follows `oc_i` by one clock. The bench drives inputs on falling edges and builds each switching cycle from a fixed clock schedule. It reads the outputs on the falling edge after the clock where each result is due: inside a cycle for the pulse-limit and cycle-tick results, and at a cycle's end for window entry.

// File: rtl/oc_tmr_pkg.sv
package oc_tmr_pkg;
  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_LIMIT = 2'd1,
    ST_TRIP  = 2'd2
  } oc_state_e;
endpackage

// File: rtl/oc_tmr_sampler.sv
// Captures the overcurrent flag a fixed delay after the low-side switch turns on.
module oc_tmr_sampler #(
  parameter int SAMPLE_DLY = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic ls_on,
  input  logic oc_in,
  output logic smp_vld,
  output logic smp_oc
);
  logic ls_q;

  always_ff @(posedge clk) begin
    if (rst || !en) ls_q <= 1'b0;
    else            ls_q <= ls_on;
  end

  generate
    if (SAMPLE_DLY < 1) begin : g_direct
      always_ff @(posedge clk) begin
        if (rst || !en) begin
          smp_vld <= 1'b0;
          smp_oc  <= 1'b0;
        end else begin
          smp_vld <= ls_on && !ls_q;
          if (ls_on && !ls_q) smp_oc <= oc_in;
        end
      end
    end else begin : g_delayed
      localparam int CW = $clog2(SAMPLE_DLY + 1);
      localparam logic [CW-1:0] DLY_V = CW'(SAMPLE_DLY);
      localparam logic [CW-1:0] ONE   = CW'(1);
      logic [CW-1:0] dly_cnt;

      always_ff @(posedge clk) begin
        if (rst || !en) begin
          dly_cnt <= '0;
          smp_vld <= 1'b0;
          smp_oc  <= 1'b0;
        end else begin
          smp_vld <= 1'b0;
          if (ls_on && !ls_q)       dly_cnt <= DLY_V;
          else if (!ls_on)          dly_cnt <= '0;
          else if (dly_cnt != '0)   dly_cnt <= dly_cnt - ONE;
          if (ls_on && ls_q && dly_cnt == ONE) begin
            smp_vld <= 1'b1;
            smp_oc  <= oc_in;
          end
        end
      end
    end
  endgenerate
endmodule

// File: rtl/oc_tmr_wincnt.sv
// Counts switching-cycle ticks while the grace window is open.
module oc_tmr_wincnt #(
  parameter int WIN_CYC = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic active,
  input  logic tick,
  output logic done
);
  localparam int W = (WIN_CYC < 2) ? 1 : $clog2(WIN_CYC);
  localparam logic [W-1:0] LAST = W'(WIN_CYC - 1);
  localparam logic [W-1:0] ONE  = W'(1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !active)  cnt <= '0;
    else if (tick)       cnt <= (cnt == LAST) ? '0 : cnt + ONE;
  end

  assign done = active && tick && (cnt == LAST);
endmodule

// File: rtl/oc_tmr_fsm.sv
// Run / current-limit / trip control with registered outputs.
module oc_tmr_fsm
  import oc_tmr_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      en,
  input  logic      smp_vld,
  input  logic      smp_oc,
  input  logic      oc_now,
  input  logic      win_done,
  output oc_state_e st_o,
  output logic      limit_o,
  output logic      shdn_o,
  output logic      term_o
);
  oc_state_e st, st_nxt;
  logic      oc_hold;
  logic      oc_latest;

  assign oc_latest = smp_vld ? smp_oc : oc_hold;

  always_comb begin
    st_nxt = st;
    unique case (st)
      ST_RUN:   if (smp_vld && smp_oc) st_nxt = ST_LIMIT;
      ST_LIMIT: if (win_done)          st_nxt = oc_latest ? ST_TRIP : ST_RUN;
      ST_TRIP:  st_nxt = ST_TRIP;
      default:  st_nxt = ST_RUN;
    endcase
    if (!en) st_nxt = ST_RUN;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_RUN;
      oc_hold <= 1'b0;
      limit_o <= 1'b0;
      shdn_o  <= 1'b0;
      term_o  <= 1'b0;
    end else begin
      st      <= st_nxt;
      oc_hold <= en ? oc_latest : 1'b0;
      limit_o <= en && (st_nxt == ST_LIMIT);
      shdn_o  <= en && (st_nxt == ST_TRIP);
      term_o  <= en && (((st == ST_LIMIT) && oc_now) || (st == ST_TRIP));
    end
  end

  assign st_o = st;
endmodule

// File: rtl/oc_delay_shutdown.sv
module oc_delay_shutdown
  import oc_tmr_pkg::*;
#(
  parameter int SAMPLE_DLY = 10,
  parameter int WIN_CYC    = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  input  logic cyc_tick_i,
  input  logic ls_on_i,
  input  logic oc_i,
  output logic cyc_term_o,
  output logic limit_o,
  output logic shutdown_o
);
  logic      smp_vld;
  logic      smp_oc;
  logic      win_done;
  oc_state_e st;

  oc_tmr_sampler #(.SAMPLE_DLY(SAMPLE_DLY)) u_sampler (
    .clk     (clk),
    .rst     (rst),
    .en      (en_i),
    .ls_on   (ls_on_i),
    .oc_in   (oc_i),
    .smp_vld (smp_vld),
    .smp_oc  (smp_oc)
  );

  oc_tmr_wincnt #(.WIN_CYC(WIN_CYC)) u_wincnt (
    .clk    (clk),
    .rst    (rst),
    .active (st == ST_LIMIT),
    .tick   (cyc_tick_i),
    .done   (win_done)
  );

  oc_tmr_fsm u_fsm (
    .clk      (clk),
    .rst      (rst),
    .en       (en_i),
    .smp_vld  (smp_vld),
    .smp_oc   (smp_oc),
    .oc_now   (oc_i),
    .win_done (win_done),
    .st_o     (st),
    .limit_o  (limit_o),
    .shdn_o   (shutdown_o),
    .term_o   (cyc_term_o)
  );
endmodule

// File: rtl/oc_delay_shutdown_chk.sv
module oc_delay_shutdown_chk (
  input logic clk,
  input logic rst,
  input logic en_i,
  input logic cyc_tick_i,
  input logic ls_on_i,
  input logic smp_vld,
  input logic smp_oc,
  input logic cyc_term_o,
  input logic limit_o,
  input logic shutdown_o
);
  assert_disable_clears_R1: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> (!limit_o && !shutdown_o && !cyc_term_o));

  assert_sample_in_on_time_R2: assert property (@(posedge clk) disable iff (rst)
    smp_vld |-> $past(ls_on_i));

  assert_window_from_sample_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(limit_o) |-> $past(smp_vld && smp_oc));

  assert_trip_on_tick_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(shutdown_o) |-> ($past(cyc_tick_i) && $past(limit_o)));

  assert_term_only_when_limiting_R5: assert property (@(posedge clk) disable iff (rst)
    cyc_term_o |-> $past(limit_o || shutdown_o));

  assert_trip_excludes_window_R6: assert property (@(posedge clk) disable iff (rst)
    !(limit_o && shutdown_o));

  assert_shutdown_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    (shutdown_o && en_i) |=> shutdown_o);
endmodule

bind oc_delay_shutdown oc_delay_shutdown_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .en_i       (en_i),
  .cyc_tick_i (cyc_tick_i),
  .ls_on_i    (ls_on_i),
  .smp_vld    (smp_vld),
  .smp_oc     (smp_oc),
  .cyc_term_o (cyc_term_o),
  .limit_o    (limit_o),
  .shutdown_o (shutdown_o)
);

// File: tb/oc_delay_shutdown_tb.sv
module oc_delay_shutdown_tb;
  localparam int D      = 10;
  localparam int WIN    = 8;
  localparam int PER    = 20;
  localparam int LS_AT  = 8;

  logic clk = 1'b0;
  logic rst, en_i, cyc_tick_i, ls_on_i, oc_i;
  logic cyc_term_o, limit_o, shutdown_o;
  int   n_checks = 0;
  int   n_fail   = 0;
  bit   finished = 0;

  always #10 clk = ~clk;

  oc_delay_shutdown #(.SAMPLE_DLY(D), .WIN_CYC(WIN)) u_dut (
    .clk(clk), .rst(rst), .en_i(en_i), .cyc_tick_i(cyc_tick_i),
    .ls_on_i(ls_on_i), .oc_i(oc_i), .cyc_term_o(cyc_term_o),
    .limit_o(limit_o), .shutdown_o(shutdown_o)
  );

  typedef struct packed {
    logic [11:0] pat;
    logic        sd;
    logic        lim;
  } vec_t;

  // bit c of pat = overcurrent during switching cycle c
  localparam vec_t VECS [10] = '{
    '{12'h000, 1'b0, 1'b0},
    '{12'h001, 1'b0, 1'b0},
    '{12'h081, 1'b1, 1'b0},
    '{12'h041, 1'b0, 1'b0},
    '{12'h408, 1'b1, 1'b0},
    '{12'h101, 1'b0, 1'b1},
    '{12'hFFF, 1'b1, 1'b0},
    '{12'h020, 1'b0, 1'b1},
    '{12'h008, 1'b0, 1'b0},
    '{12'h181, 1'b1, 1'b0}
  };

  task automatic check(input string req, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; en_i = 1'b1; cyc_tick_i = 1'b0; ls_on_i = 1'b0; oc_i = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  // One switching cycle; outputs are captured after clock edge 'probe'.
  task automatic run_cycle(input logic oc, input int probe,
                           output logic t, output logic l, output logic s);
    t = 1'b0; l = 1'b0; s = 1'b0;
    for (int k = 0; k < PER; k++) begin
      cyc_tick_i = (k == 0);
      ls_on_i    = (k >= LS_AT);
      oc_i       = oc && (k >= LS_AT);
      @(negedge clk);
      if (k == probe) begin
        t = cyc_term_o; l = limit_o; s = shutdown_o;
      end
    end
    cyc_tick_i = 1'b0; ls_on_i = 1'b0; oc_i = 1'b0;
  endtask

  task automatic ls_pulse(input int len);
    for (int k = 0; k < len; k++) begin
      ls_on_i = 1'b1; oc_i = 1'b1;
      @(negedge clk);
    end
    ls_on_i = 1'b0; oc_i = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic t, l, s;
    @(negedge clk);

    // R1: reset state
    do_reset();
    @(negedge clk);
    check("R1 reset term", cyc_term_o, 1'b0);
    check("R1 reset limit", limit_o, 1'b0);
    check("R1 reset shutdown", shutdown_o, 1'b0);

    // Vector table: 12 cycles per pattern, final state checked
    for (int v = 0; v < 10; v++) begin
      do_reset();
      for (int c = 0; c < 12; c++) run_cycle(VECS[v].pat[c], 0, t, l, s);
      check($sformatf("R4 R6 R7 R9 vector %0d shutdown", v), shutdown_o, VECS[v].sd);
      check($sformatf("R4 R6 R7 R9 vector %0d limit", v), limit_o, VECS[v].lim);
    end

    // R2: low-side pulse exactly SAMPLE_DLY clocks -> no capture
    do_reset();
    ls_pulse(D);
    check("R2 short pulse no capture", limit_o, 1'b0);
    // R2: one clock longer -> capture, R3 window opens
    ls_pulse(D + 1);
    check("R2 R3 capture opens window", limit_o, 1'b1);

    // R5 in normal operation, R3 entry, R5 inside the window
    do_reset();
    run_cycle(1'b1, 12, t, l, s);
    check("R5 no term in normal", t, 1'b0);
    check("R3 window after detect", limit_o, 1'b1);
    run_cycle(1'b1, 10, t, l, s);
    check("R5 term in window with oc", t, 1'b1);
    run_cycle(1'b1, 5, t, l, s);
    check("R5 no term in window without oc", t, 1'b0);
    for (int c = 3; c < WIN; c++) run_cycle(1'b1, 0, t, l, s);
    check("R4 still limiting before last tick", limit_o, 1'b1);
    check("R4 no shutdown before last tick", shutdown_o, 1'b0);
    // next cycle's tick is the WIN-th: trip
    run_cycle(1'b0, 0, t, l, s);
    check("R6 trip at window end", s, 1'b1);
    check("R6 limit drops at trip", l, 1'b0);

    // R8: sticky with no overcurrent, term held
    run_cycle(1'b0, 3, t, l, s);
    check("R8 shutdown held", s, 1'b1);
    check("R8 term held in trip", t, 1'b1);
    run_cycle(1'b0, 0, t, l, s);
    check("R8 shutdown held later", shutdown_o, 1'b1);

    // R1: disable clears the latch
    en_i = 1'b0;
    @(negedge clk);
    check("R1 disable clears shutdown", shutdown_o, 1'b0);
    check("R1 disable clears term", cyc_term_o, 1'b0);
    en_i = 1'b1;
    run_cycle(1'b0, 0, t, l, s);
    check("R1 stays clear after re-enable", shutdown_o, 1'b0);

    // R7: resume, then R9 full-length fresh window
    do_reset();
    run_cycle(1'b1, 0, t, l, s);
    for (int c = 1; c < WIN; c++) run_cycle(c == 3, 0, t, l, s);
    run_cycle(1'b1, 1, t, l, s);
    check("R7 resume at window end", l, 1'b0);
    check("R7 no shutdown on resume", s, 1'b0);
    check("R9 fresh window opens", limit_o, 1'b1);
    for (int c = 1; c < WIN; c++) run_cycle(1'b1, 0, t, l, s);
    check("R9 fresh window full length", shutdown_o, 1'b0);
    run_cycle(1'b0, 0, t, l, s);
    check("R9 trip at fresh window end", s, 1'b1);

    // R1: reset in the middle of a window
    do_reset();
    run_cycle(1'b1, 0, t, l, s);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1 reset closes window", limit_o, 1'b0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule